// File: doc/BRIEF.md
# Load-Use Interlock and Branch Squash Controller

This block is the hazard controller of a five-stage in-order pipeline. It watches two pipeline registers: the one between fetch and decode, and the one between decode and execute. When the instruction in execute is a load whose destination register is a source of the instruction in decode, the block holds fetch and decode for one cycle. During that cycle it keeps the program counter and the fetch/decode register from updating. It also selects all-zero control bits into the decode/execute register, so the held slot moves forward as a bubble that writes nothing. After the bubble, the forwarding network can supply the loaded value.

Branches are predicted not taken, so sequential fetch goes on past a branch. The branch resolves in decode: the datapath compares the two source registers for equality and the block receives the result. When a branch in decode is taken, the block steers the program counter to the branch target. The target is PC+4 plus the sign-extended offset shifted left by two, and the datapath computes it. In the same cycle the block clears the fetch/decode register, so the one wrongly fetched instruction becomes an all-zero word that decodes as a no-op. If a load-use stall and a taken branch occur in the same cycle, the stall wins and the branch is evaluated again on the next cycle.

A small state bit records that a stall was issued in the previous cycle. It limits every interlock to exactly one cycle.

Top module: `hz_ctrl`

## Requirements
- R1: When `idex_mem_read` is 1, `idex_rt` is nonzero and `idex_rt` equals `ifid_rs` or `ifid_rt`, and no stall was issued in the previous cycle, the block stalls in that same cycle (`bubble_sel` = 1).
- R2: While stalling, `pc_en` = 0, `fetch_reg_en` = 0 and `bubble_sel` = 1. In every other cycle, `pc_en` = 1, `fetch_reg_en` = 1 and `bubble_sel` = 0.
- R3: There is no stall when `idex_mem_read` is 0, or when `idex_rt` matches neither decode source.
- R4: Register number 0 never causes a stall, even when all three register fields are 0.
- R5: A stall lasts exactly one cycle. The cycle after a stall never stalls, even if the match condition is still present.
- R6: When `id_branch` = 1, `id_regs_equal` = 1 and there is no stall, `pc_src` = 1 and `fetch_flush` = 1 in that same cycle.
- R7: When `id_branch` = 0 or `id_regs_equal` = 0, `pc_src` = 0 and `fetch_flush` = 0, so sequential fetch continues.
- R8: A stall takes priority over a taken branch: in the stall cycle, `pc_src` = 0 and `fetch_flush` = 0. In the next cycle, with the same branch inputs, the branch is taken.
- R9: Reset (`rst_n` = 0, asynchronous) clears the stall history. The first cycle after reset with no hazard shows `pc_en` = `fetch_reg_en` = 1, and a load-use match in that first cycle stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idex_mem_read | input | 1 | Instruction in execute is a load |
| idex_rt | input | AW (5) | Destination register of the load in execute |
| ifid_rs | input | AW (5) | First source register of the instruction in decode |
| ifid_rt | input | AW (5) | Second source register of the instruction in decode |
| id_branch | input | 1 | Instruction in decode is a conditional branch |
| id_regs_equal | input | 1 | Decode-stage comparator found both sources equal |
| pc_en | output | 1 | Program counter update enable |
| fetch_reg_en | output | 1 | Fetch/decode register update enable |
| bubble_sel | output | 1 | Select zero control bits into decode/execute |
| fetch_flush | output | 1 | Clear the fetch/decode register to an all-zero word |
| pc_src | output | 1 | Select the branch target as the next program counter |

## Verification
The assertions assume the following about the inputs:
- They change only just after a rising edge and are known, never X, when sampled.
- Reset is released between edges.
- Each stimulus step lasts exactly one clock, so the stall history seen by the design matches what the bench expects.

The bench follows these assumptions by driving every input 1 ns after the rising edge, comparing outputs at the falling edge, and issuing one step per cycle with no gaps. This keeps its model of the previous-cycle stall in step with the design. The stimulus holds a hazard for two cycles in a row on purpose, to reach the one-cycle limit and the deferred branch.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // True when a produced register number feeds a consumer, ignoring register 0.
  function automatic logic reg_feeds(input logic [7:0] dst, input logic [7:0] src);
    return (dst != 8'd0) && (dst == src);
  endfunction

  // A branch redirects fetch only when it is present, its operands compare equal, and no interlock holds it.
  function automatic logic branch_redirect(input logic is_br, input logic eq, input logic held);
    return is_br && eq && !held;
  endfunction

endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                    ld_valid,
  input  logic [AW-1:0]           ld_dst,
  input  logic [NSRC-1:0][AW-1:0] srcs,
  output logic                    hit
);
  import hz_pkg::*;

  logic [NSRC-1:0] per_src;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [7:0] d8, s8;
    assign d8 = 8'(ld_dst);
    assign s8 = 8'(srcs[i]);
    assign per_src[i] = reg_feeds(d8, s8);
  end

  assign hit = ld_valid && (|per_src);
endmodule

// File: rtl/hz_branch.sv
module hz_branch (
  input  logic is_branch,
  input  logic regs_equal,
  input  logic held,
  output logic redirect
);
  import hz_pkg::*;

  assign redirect = branch_redirect(is_branch, regs_equal, held);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idex_mem_read,
  input  logic [AW-1:0] idex_rt,
  input  logic [AW-1:0] ifid_rs,
  input  logic [AW-1:0] ifid_rt,
  input  logic          id_branch,
  input  logic          id_regs_equal,
  output logic          pc_en,
  output logic          fetch_reg_en,
  output logic          bubble_sel,
  output logic          fetch_flush,
  output logic          pc_src
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] dec_srcs;
  logic                    load_use_hit;   // raw match, before the one-cycle guard
  logic                    stalled_q;      // a stall was issued last cycle
  logic                    stall_now;
  logic                    br_taken;

  assign dec_srcs[0] = ifid_rs;
  assign dec_srcs[1] = ifid_rt;

  hz_load_use #(.AW(AW), .NSRC(NSRC)) u_lu (
    .ld_valid (idex_mem_read),
    .ld_dst   (idex_rt),
    .srcs     (dec_srcs),
    .hit      (load_use_hit)
  );

  assign stall_now = load_use_hit && !stalled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= stall_now;
  end

  hz_branch u_br (
    .is_branch  (id_branch),
    .regs_equal (id_regs_equal),
    .held       (stall_now),
    .redirect   (br_taken)
  );

  assign pc_en        = !stall_now;
  assign fetch_reg_en = !stall_now;
  assign bubble_sel   = stall_now;
  assign fetch_flush  = br_taken;
  assign pc_src       = br_taken;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idex_mem_read,
  input logic [AW-1:0] idex_rt,
  input logic [AW-1:0] ifid_rs,
  input logic [AW-1:0] ifid_rt,
  input logic          id_branch,
  input logic          id_regs_equal,
  input logic          pc_en,
  input logic          fetch_reg_en,
  input logic          bubble_sel,
  input logic          fetch_flush,
  input logic          pc_src,
  input logic          load_use_hit
);
  logic src_match;
  assign src_match = (idex_rt == ifid_rs) || (idex_rt == ifid_rt);

  assert_hit_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_mem_read && idex_rt != '0 && src_match && !$past(bubble_sel)) |-> bubble_sel);

  assert_stall_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |-> (!pc_en && !fetch_reg_en));

  assert_run_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble_sel |-> (pc_en && fetch_reg_en));

  assert_no_load_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idex_mem_read || !src_match) |-> !bubble_sel);

  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rt == '0) |-> (!bubble_sel && !load_use_hit));

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> !bubble_sel);

  assert_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch && id_regs_equal && !bubble_sel) |-> (pc_src && fetch_flush));

  assert_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_branch && id_regs_equal) |-> (!pc_src && !fetch_flush));

  assert_stall_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |-> (!pc_src && !fetch_flush));
endmodule

bind hz_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_hz_ctrl.sv
`timescale 1ns/1ps
module tb_hz_ctrl;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          idex_mem_read = 1'b0;
  logic [AW-1:0] idex_rt = '0, ifid_rs = '0, ifid_rt = '0;
  logic          id_branch = 1'b0, id_regs_equal = 1'b0;
  logic          pc_en, fetch_reg_en, bubble_sel, fetch_flush, pc_src;

  always #2.5 clk = ~clk;

  hz_ctrl #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .idex_mem_read(idex_mem_read), .idex_rt(idex_rt),
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
    .id_branch(id_branch), .id_regs_equal(id_regs_equal),
    .pc_en(pc_en), .fetch_reg_en(fetch_reg_en), .bubble_sel(bubble_sel),
    .fetch_flush(fetch_flush), .pc_src(pc_src)
  );

  typedef struct {
    string      tag;
    logic [4:0] exp;   // {pc_en, fetch_reg_en, bubble_sel, fetch_flush, pc_src}
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    prev_stall = 1'b0;
  bit    done = 1'b0;

  // Driver: applies one cycle of inputs and predicts the outputs from the requirements.
  task automatic step(input string tag, input bit mr, input int rt, input int rs,
                      input int rtd, input bit br, input bit eq);
    item_t it;
    bit    hazard, stall, take;
    @(posedge clk);
    #1;
    idex_mem_read = mr; idex_rt = AW'(rt); ifid_rs = AW'(rs); ifid_rt = AW'(rtd);
    id_branch = br; id_regs_equal = eq;
    hazard = 1'b0;
    if (mr && rt != 0) hazard = (rs == rt) || (rtd == rt);
    stall = hazard && !prev_stall;
    take  = br && eq && !stall;
    prev_stall = stall;
    it.tag = tag;
    it.exp = {~stall, ~stall, stall, take, take};
    q.push_back(it);
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it  = q.pop_front();
      act = {pc_en, fetch_reg_en, bubble_sel, fetch_flush, pc_src};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got %b expected %b (pc_en,fetch_reg_en,bubble_sel,fetch_flush,pc_src)",
                 it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    prev_stall = 1'b0;
    step("R9 idle after reset",       0, 0, 0, 0, 0, 0);
    step("R9 R1 stall on rs match",   1, 3, 3, 1, 0, 0);
    step("R5 no second stall",        1, 3, 3, 1, 0, 0);
    step("R1 stall on rt match",      1, 7, 1, 7, 0, 0);
    step("R3 load with no match",     1, 7, 2, 4, 0, 0);
    step("R3 match without load",     0, 5, 5, 5, 0, 0);
    step("R4 register zero",          1, 0, 0, 0, 0, 0);
    step("R6 taken branch",           0, 0, 1, 2, 1, 1);
    step("R7 branch not equal",       0, 0, 1, 2, 1, 0);
    step("R7 equal but no branch",    0, 0, 1, 2, 0, 1);
    step("R8 stall beats branch",     1, 9, 9, 4, 1, 1);
    step("R8 branch taken after",     1, 9, 9, 4, 1, 1);
    step("R1 top register",           1, 31, 6, 31, 0, 0);
    step("R2 run enables",            0, 31, 31, 31, 0, 0);
    // Mixed pattern: hazard runs of varying length interleaved with branches.
    for (int k = 0; k < 24; k++) begin
      step("R2 R5 R6 mixed", (k % 4) != 3, (k % 3) + (k % 5), k % 3, (k % 7) % 3,
           (k % 5) == 1, (k % 2) == 0);
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule